// File: doc/BRIEF.md
# Servo Code-Edge Search Controller

This block is the digital half of a servo loop that finds where a converter under test changes from one output code to the next. Each conversion result is compared with a target code. An up/down accumulator drives the stimulus word sent to an external DAC. The word moves down by one step when the result is at or above the target, and up by one step when it is below. The stimulus moves on every conversion, with no averaging first. Once it reaches the transition, it dithers back and forth across it.

A run starts in search mode. When enough direction reversals occur in a row, the loop is taken as locked. The controller then sums a fixed, power-of-two window of stimulus words and shifts the sum down. The result is the estimate of the lower edge of the target code. It is reported with a one-cycle done pulse. In single mode one target is measured. In sweep mode the controller walks the target over every edge of the converter, from code 1 up to the top code. That is 2^N − 1 edges for an N-bit converter. A search that does not lock within a set number of conversions ends with an error flag.

Top module: `servo_edge_ctrl`

## Requirements
- R1: For each valid conversion while busy, `dac_word` in the next cycle is the old word minus `step_size` if `adc_code >= target`, or the old word plus `step_size` if `adc_code < target`.
- R2: The stimulus saturates instead of wrapping. A downward step that would go below 0 gives 0. An upward step that would exceed 2^DAC_W − 1 gives 2^DAC_W − 1.
- R3: While idle, a valid conversion leaves `dac_word` unchanged. `dac_word` also never changes in a cycle without a valid conversion.
- R4: A reversal is a search conversion whose direction differs from the previous search conversion of the same edge. The first conversion of an edge is never a reversal, and any non-reversal resets the count to zero. The loop locks on the conversion that brings the count of consecutive reversals to `lock_revs`.
- R5: After lock, the next 2^AVG_LOG2 conversions are the averaging window. For each of them the value `dac_word` held when the conversion arrived is summed, and stepping continues. On the cycle after the last one, `done` is high for one cycle, with `edge_value` = sum >> AVG_LOG2, `edge_code` = target and `timeout_err` = 0.
- R6: If the search conversions of an edge reach `tmo_lim` without locking, then on the next cycle `done` and `timeout_err` are high for one cycle, `edge_code` shows the target, and the controller goes idle. This ends any sweep in progress.
- R7: In sweep mode the targets are 1, 2, … up to 2^CODE_W − 1 in order, with one done per edge. `busy` stays high between edges and drops with the last done.
- R8: A `start` pulse while idle makes `busy` high on the next cycle. Single mode uses `target_in` as the target.
- R9: After reset, `dac_word` is mid-scale (2^(DAC_W−1)), and `busy`, `done` and `timeout_err` are low.
- R10: A `start` pulse while busy is ignored, and the run in progress keeps its target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a run when idle |
| sweep | input | 1 | Sampled at start: 1 walks all edges, 0 measures `target_in` only |
| target_in | input | CODE_W | Target code for single mode |
| step_size | input | STEP_W | Integrator step in DAC LSBs |
| lock_revs | input | REV_W | Consecutive reversals needed for lock |
| tmo_lim | input | TMO_W | Search conversions allowed before timeout |
| adc_code | input | CODE_W | Converter output code |
| adc_valid | input | 1 | Strobe marking one new conversion |
| dac_word | output | DAC_W | Stimulus word to the DAC |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse: an edge result or a timeout is reported |
| timeout_err | output | 1 | Qualifies `done`: the search timed out |
| edge_code | output | CODE_W | Target code of the reported result |
| edge_value | output | DAC_W | Averaged stimulus at the edge |

## Verification
The two hardest cases to reach from the ports are the saturated rails and the timeout. A well-behaved converter never lets the loop sit at either end of the range. So the bench uses a converter model that is pinned: the target is zero, so every result is at or above it, or the output code is stuck at zero with a non-zero target. The stimulus is then driven into the floor or the ceiling until the timeout fires. Lock, the averaging window and the sweep order are reached with a converter model that adds bounded random noise to an ideal quantizer. A noise-free directed case has a closed-form edge value.

// File: rtl/servo_pkg.sv
package servo_pkg;
   typedef enum logic [1:0] {
      SV_IDLE = 2'd0,
      SV_SEEK = 2'd1,
      SV_AVG  = 2'd2
   } sv_phase_t;
endpackage

// File: rtl/servo_integrator.sv
module servo_integrator #(
   parameter int DAC_W  = 10,
   parameter int STEP_W = 6,
   parameter logic [DAC_W-1:0] INIT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              down,
   input  logic [STEP_W-1:0] step,
   output logic [DAC_W-1:0]  word
);
   localparam int WW = DAC_W + 1;
   localparam logic [WW-1:0] TOPW = {1'b0, {DAC_W{1'b1}}};

   logic [WW-1:0] wide_word, wide_step, raised, nxt;

   assign wide_word = {1'b0, word};
   assign wide_step = {{(WW-STEP_W){1'b0}}, step};
   assign raised    = wide_word + wide_step;

   always_comb begin
      if (down) nxt = (wide_word < wide_step) ? '0 : wide_word - wide_step;
      else      nxt = (raised > TOPW) ? TOPW : raised;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word <= INIT;
      else if (en) word <= DAC_W'(nxt);
   end
endmodule

// File: rtl/servo_lock_det.sv
module servo_lock_det #(
   parameter int REV_W = 4,
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             conv,
   input  logic             down,
   input  logic [REV_W-1:0] lock_revs,
   input  logic [TMO_W-1:0] tmo_lim,
   output logic             lock,
   output logic             tmo_hit
);
   logic             have, last_down, reversal;
   logic [REV_W-1:0] revs, revs_nxt;
   logic [TMO_W-1:0] tmo, tmo_nxt;

   always_comb begin
      reversal = conv && have && (down != last_down);
      if (!reversal)       revs_nxt = '0;
      else if (&revs)      revs_nxt = revs;
      else                 revs_nxt = revs + 1'b1;
      tmo_nxt  = (&tmo) ? tmo : tmo + 1'b1;
      lock     = reversal && (revs_nxt >= lock_revs);
      tmo_hit  = conv && !lock && (tmo_nxt >= tmo_lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have <= 1'b0; last_down <= 1'b0; revs <= '0; tmo <= '0;
      end else if (clear) begin
         have <= 1'b0; last_down <= 1'b0; revs <= '0; tmo <= '0;
      end else if (conv) begin
         have      <= 1'b1;
         last_down <= down;
         revs      <= revs_nxt;
         tmo       <= tmo_nxt;
      end
   end
endmodule

// File: rtl/servo_block_avg.sv
module servo_block_avg #(
   parameter int DAC_W    = 10,
   parameter int AVG_LOG2 = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             take,
   input  logic [DAC_W-1:0] sample,
   output logic             full,
   output logic [DAC_W-1:0] mean
);
   generate
      if (AVG_LOG2 == 0) begin : g_pass
         assign full = take;
         assign mean = sample;
      end else begin : g_sum
         localparam int SUM_W = DAC_W + AVG_LOG2;
         logic [SUM_W-1:0]    acc, total;
         logic [AVG_LOG2-1:0] cnt;

         assign total = acc + {{AVG_LOG2{1'b0}}, sample};
         assign full  = take && (&cnt);
         assign mean  = DAC_W'(total >> AVG_LOG2);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc <= '0; cnt <= '0;
            end else if (clear) begin
               acc <= '0; cnt <= '0;
            end else if (take) begin
               cnt <= cnt + 1'b1;
               acc <= full ? '0 : total;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/servo_edge_ctrl.sv
module servo_edge_ctrl #(
   parameter int CODE_W   = 6,
   parameter int DAC_W    = 10,
   parameter int STEP_W   = 6,
   parameter int REV_W    = 4,
   parameter int TMO_W    = 16,
   parameter int AVG_LOG2 = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              sweep,
   input  logic [CODE_W-1:0] target_in,
   input  logic [STEP_W-1:0] step_size,
   input  logic [REV_W-1:0]  lock_revs,
   input  logic [TMO_W-1:0]  tmo_lim,
   input  logic [CODE_W-1:0] adc_code,
   input  logic              adc_valid,
   output logic [DAC_W-1:0]  dac_word,
   output logic              busy,
   output logic              done,
   output logic              timeout_err,
   output logic [CODE_W-1:0] edge_code,
   output logic [DAC_W-1:0]  edge_value
);
   import servo_pkg::*;

   localparam logic [DAC_W-1:0]  MID_WORD   = {1'b1, {(DAC_W-1){1'b0}}};
   localparam logic [CODE_W-1:0] FIRST_CODE = CODE_W'(1);
   localparam logic [CODE_W-1:0] LAST_CODE  = '1;

   generate
      if (CODE_W > DAC_W) begin : g_bad_code
         $error("CODE_W must not exceed DAC_W");
      end
      if (STEP_W > DAC_W) begin : g_bad_step
         $error("STEP_W must not exceed DAC_W");
      end
      if (AVG_LOG2 > 16) begin : g_bad_avg
         $error("AVG_LOG2 out of range");
      end
   endgenerate

   sv_phase_t         phase;
   logic [CODE_W-1:0] tgt_q;
   logic              sweep_q;
   logic              conv, down, seek_conv, avg_take;
   logic              lock, tmo_hit, avg_full, next_edge;
   logic [DAC_W-1:0]  avg_mean;

   assign busy      = (phase != SV_IDLE);
   assign conv      = adc_valid && busy;
   assign down      = (adc_code >= tgt_q);
   assign seek_conv = conv && (phase == SV_SEEK);
   assign avg_take  = conv && (phase == SV_AVG);
   assign next_edge = avg_full && sweep_q && (tgt_q != LAST_CODE);

   servo_integrator #(.DAC_W(DAC_W), .STEP_W(STEP_W), .INIT(MID_WORD)) integ_i (
      .clk(clk), .rst_n(rst_n), .en(conv), .down(down),
      .step(step_size), .word(dac_word)
   );

   servo_lock_det #(.REV_W(REV_W), .TMO_W(TMO_W)) lock_i (
      .clk(clk), .rst_n(rst_n), .clear((phase == SV_IDLE) || next_edge),
      .conv(seek_conv), .down(down), .lock_revs(lock_revs),
      .tmo_lim(tmo_lim), .lock(lock), .tmo_hit(tmo_hit)
   );

   servo_block_avg #(.DAC_W(DAC_W), .AVG_LOG2(AVG_LOG2)) avg_i (
      .clk(clk), .rst_n(rst_n), .clear(phase != SV_AVG), .take(avg_take),
      .sample(dac_word), .full(avg_full), .mean(avg_mean)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase       <= SV_IDLE;
         tgt_q       <= '0;
         sweep_q     <= 1'b0;
         done        <= 1'b0;
         timeout_err <= 1'b0;
         edge_code   <= '0;
         edge_value  <= '0;
      end else begin
         done        <= 1'b0;
         timeout_err <= 1'b0;
         unique case (phase)
            SV_IDLE: if (start) begin
               tgt_q   <= sweep ? FIRST_CODE : target_in;
               sweep_q <= sweep;
               phase   <= SV_SEEK;
            end
            SV_SEEK: if (lock) begin
               phase <= SV_AVG;
            end else if (tmo_hit) begin
               done        <= 1'b1;
               timeout_err <= 1'b1;
               edge_code   <= tgt_q;
               phase       <= SV_IDLE;
            end
            SV_AVG: if (avg_full) begin
               done       <= 1'b1;
               edge_code  <= tgt_q;
               edge_value <= avg_mean;
               if (next_edge) begin
                  tgt_q <= tgt_q + 1'b1;
                  phase <= SV_SEEK;
               end else begin
                  phase <= SV_IDLE;
               end
            end
            default: phase <= SV_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/servo_edge_ctrl_chk.sv
module servo_edge_ctrl_chk #(
   parameter int CODE_W = 6,
   parameter int DAC_W  = 10,
   parameter int STEP_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              adc_valid,
   input logic [CODE_W-1:0] adc_code,
   input logic [CODE_W-1:0] tgt_q,
   input logic [STEP_W-1:0] step_size,
   input logic [DAC_W-1:0]  dac_word,
   input logic              busy,
   input logic              done,
   input logic              timeout_err
);
   localparam logic [DAC_W:0] TOPW = {1'b0, {DAC_W{1'b1}}};
   logic [DAC_W:0] step_x, word_x;
   logic           stepping;
   assign step_x   = {{(DAC_W+1-STEP_W){1'b0}}, step_size};
   assign word_x   = {1'b0, dac_word};
   assign stepping = adc_valid && busy;

   // R1
   step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stepping && (adc_code >= tgt_q) && (word_x >= step_x)
      |=> {1'b0, dac_word} == $past(word_x) - $past(step_x));
   // R1
   step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stepping && (adc_code < tgt_q) && (word_x + step_x <= TOPW)
      |=> {1'b0, dac_word} == $past(word_x) + $past(step_x));
   // R2
   floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stepping && (adc_code >= tgt_q) && (word_x < step_x) |=> dac_word == '0);
   // R2
   ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stepping && (adc_code < tgt_q) && (word_x + step_x > TOPW) |=> dac_word == '1);
   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stepping |=> $stable(dac_word));
   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R6
   err_ends_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err |-> done && !busy);
endmodule

bind servo_edge_ctrl servo_edge_ctrl_chk #(
   .CODE_W(CODE_W), .DAC_W(DAC_W), .STEP_W(STEP_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .adc_valid(adc_valid), .adc_code(adc_code),
   .tgt_q(tgt_q), .step_size(step_size), .dac_word(dac_word),
   .busy(busy), .done(done), .timeout_err(timeout_err)
);

// File: tb/servo_edge_ctrl_tb_top.sv
module servo_edge_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CODE_W = 6, DAC_W = 10, STEP_W = 6, REV_W = 4, TMO_W = 16, AVG_LOG2 = 4;
   localparam int WIN = 1 << AVG_LOG2;
   localparam int MAXD = (1 << DAC_W) - 1;
   localparam int MAXC = (1 << CODE_W) - 1;
   localparam int QSH = DAC_W - CODE_W;

   logic clk = 0, rst_n = 0, start = 0, sweep = 0, adc_valid = 0;
   logic [CODE_W-1:0] target_in = '0, adc_code = '0;
   logic [STEP_W-1:0] step_size = '0;
   logic [REV_W-1:0]  lock_revs = '0;
   logic [TMO_W-1:0]  tmo_lim = '0;
   logic [DAC_W-1:0]  dac_word, edge_value;
   logic [CODE_W-1:0] edge_code;
   logic busy, done, timeout_err;

   always #(CLK_PERIOD/2) clk = ~clk;

   servo_edge_ctrl #(.CODE_W(CODE_W), .DAC_W(DAC_W), .STEP_W(STEP_W), .REV_W(REV_W),
      .TMO_W(TMO_W), .AVG_LOG2(AVG_LOG2)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .sweep(sweep), .target_in(target_in),
      .step_size(step_size), .lock_revs(lock_revs), .tmo_lim(tmo_lim),
      .adc_code(adc_code), .adc_valid(adc_valid), .dac_word(dac_word), .busy(busy),
      .done(done), .timeout_err(timeout_err), .edge_code(edge_code), .edge_value(edge_value));

   int total = 0, bad = 0;
   bit finished = 0;
   int noise_amp = 0, stuck_en = 0, stuck_code = 0;
   int m_phase = 0, m_tgt = 0, m_have = 0, m_last = 0, m_revs = 0, m_tmo = 0;
   int m_sum = 0, m_n = 0, m_sweep = 0, m_step = 0, m_lock = 0, m_tlim = 0;
   int sweep_dones = 0, last_value = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int sat_step(input int d, input int dn, input int s);
      if (dn != 0) return (d < s) ? 0 : d - s;
      return (d + s > MAXD) ? MAXD : d + s;
   endfunction

   function automatic int adc_of(input int d);
      int v;
      if (stuck_en != 0) return stuck_code;
      v = d + $signed($urandom_range(2 * noise_amp)) - noise_amp;
      if (v < 0) v = 0;
      v = v >> QSH;
      return (v > MAXC) ? MAXC : v;
   endfunction

   task automatic convert();
      int d, c, dir, rev, exp_d, e_done, e_err, e_code, e_val;
      string rq;
      @(negedge clk);
      d = int'(dac_word); c = adc_of(d);
      adc_code = CODE_W'(c); adc_valid = 1'b1;
      e_done = 0; e_err = 0; e_code = 0; e_val = 0;
      exp_d = d; rq = "R3";
      if (m_phase != 0) begin
         dir = (c >= m_tgt) ? 1 : 0;
         exp_d = sat_step(d, dir, m_step);
         rq = ((dir != 0 && d < m_step) || (dir == 0 && d + m_step > MAXD)) ? "R2" : "R1";
      end
      if (m_phase == 1) begin
         rev = (m_have != 0 && dir != m_last) ? 1 : 0;
         m_revs = (rev != 0) ? m_revs + 1 : 0;
         m_have = 1; m_last = dir; m_tmo++;
         if (rev != 0 && m_revs >= m_lock) begin
            m_phase = 2; m_sum = 0; m_n = 0;
         end else if (m_tmo >= m_tlim) begin
            e_done = 1; e_err = 1; e_code = m_tgt; m_phase = 0;
         end
      end else if (m_phase == 2) begin
         m_sum += d; m_n++;
         if (m_n == WIN) begin
            e_done = 1; e_code = m_tgt; e_val = m_sum >> AVG_LOG2;
            if (m_sweep != 0 && m_tgt < MAXC) begin
               m_tgt++; m_phase = 1; m_have = 0; m_revs = 0; m_tmo = 0;
            end else m_phase = 0;
         end
      end
      @(negedge clk);
      adc_valid = 1'b0;
      chk(int'(dac_word) == exp_d, rq, int'(dac_word), exp_d);
      chk(int'(done) == e_done, (e_err != 0) ? "R6" : "R4", int'(done), e_done);
      if (e_done != 0) begin
         chk(int'(timeout_err) == e_err, (e_err != 0) ? "R6" : "R5", int'(timeout_err), e_err);
         chk(int'(edge_code) == e_code, (m_sweep != 0) ? "R7" : "R5", int'(edge_code), e_code);
         if (e_err == 0) begin
            chk(int'(edge_value) == e_val, "R5", int'(edge_value), e_val);
            last_value = e_val;
         end
         if (m_sweep != 0) sweep_dones++;
      end
   endtask

   task automatic begin_run(input int sw, input int tg, input int st, input int lk, input int tl);
      @(negedge clk);
      sweep = sw[0]; target_in = CODE_W'(tg); step_size = STEP_W'(st);
      lock_revs = REV_W'(lk); tmo_lim = TMO_W'(tl); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      m_phase = 1; m_tgt = (sw != 0) ? 1 : tg; m_sweep = sw;
      m_have = 0; m_revs = 0; m_tmo = 0; m_step = st; m_lock = lk; m_tlim = tl;
      chk(busy == 1'b1, "R8", int'(busy), 1);
   endtask

   task automatic finish_run(input int max_conv);
      for (int i = 0; i < max_conv && m_phase != 0; i++) convert();
      chk(busy == 1'b0, "R8", int'(busy), 0);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(int'(dac_word) == (1 << (DAC_W - 1)), "R9", int'(dac_word), 1 << (DAC_W - 1));
      chk(busy == 1'b0 && done == 1'b0 && timeout_err == 1'b0, "R9",
          int'({busy, done, timeout_err}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R3 idle conversions do not move the stimulus
      for (int i = 0; i < 3; i++) convert();

      // R5 directed noise-free case: dither 304/320 gives 312
      noise_amp = 0;
      begin_run(0, 20, 16, 3, 2000);
      finish_run(3000);
      chk(last_value == 312, "R5", last_value, 312);

      // R10 start while busy keeps the original target
      begin_run(0, 30, 4, 2, 2000);
      @(negedge clk); target_in = CODE_W'(7); start = 1'b1;
      @(negedge clk); start = 1'b0;
      finish_run(3000);
      chk(int'(edge_code) == 30, "R10", int'(edge_code), 30);

      // R2/R6 floor: target 0 always steps down
      begin_run(0, 0, 8, 2, 100);
      finish_run(200);
      chk(int'(dac_word) == 0, "R2", int'(dac_word), 0);
      chk(int'(edge_code) == 0, "R6", int'(edge_code), 0);

      // R2/R6 ceiling: stuck-low converter always steps up
      stuck_en = 1; stuck_code = 0;
      begin_run(0, 5, 7, 2, 200);
      finish_run(300);
      chk(int'(dac_word) == MAXD, "R2", int'(dac_word), MAXD);
      stuck_en = 0;

      // R4 random runs with noise
      for (int k = 0; k < 6; k++) begin
         noise_amp = $urandom_range(6);
         begin_run(0, $urandom_range(58) + 2, $urandom_range(11) + 1,
                   $urandom_range(4) + 2, 5000);
         finish_run(6000);
      end

      // R7 sweep over all edges
      noise_amp = 1; sweep_dones = 0;
      begin_run(1, 0, 3, 2, 3000);
      finish_run(40000);
      chk(sweep_dones == MAXC, "R7", sweep_dones, MAXC);
      chk(int'(edge_code) == MAXC, "R7", int'(edge_code), MAXC);

      summary();
   end
endmodule